// File: doc/BRIEF.md
# Sequenced Half-Duplex SPI Master

This block is an SPI master for serial-flash style traffic, driven through a small register port. Software fills a 32-bit command word and a data buffer of `DATA_WORDS` 32-bit words. It programs three bit counts: command, transmit-data and receive. It then writes the start bit. The block runs one transaction in which the command bits go out first, then the transmit-data bits, and then the receive bits are captured back into the same data buffer. A phase whose count is zero is skipped.

SCLK uses mode 0 only. The clock idles low, MOSI changes while SCLK is low, and MISO is sampled on the rising edge. The SCLK period is a programmable number of system clocks. The chip selects are plain register bits that software sets around a sequence of transactions. A status bit reports when a transaction is in progress. While that bit is set, every register write is ignored.

Top module: `spi_seq_master`

## Requirements
- R1: Register reads return data combinationally in the cycle `reg_en` is high with `reg_we` low. Offsets: 0x00 control/status (bit 16 = busy), 0x04 command word, 0x08 + 4*w data word w, 0x28 mode, 0x2C counts, 0x38 chip select. The command word, data words, counts and chip-select register read back what was written.
- R2: Writing 0x00 with bit 8 set starts a transaction when the summed bit count is nonzero. With all three counts zero, busy stays low and no SCLK pulse is produced.
- R3: SCLK idles low. During a transaction each bit lasts P = div + 2 system clocks, where div is mode bits [27:16]. SCLK is high for the last floor(P/2) clocks of each bit.
- R4: The counts register holds the command bit count at [29:24], the receive bit count at [20:12] and the transmit bit count at [8:0]. The phases run command, then transmit, then receive. A command count above 32 acts as 32, and a data count above 32*DATA_WORDS acts as that limit. The number of SCLK pulses equals the sum of the counts.
- R5: Command bytes are sent from the most significant byte of the command word (bits [31:24]) downwards.
- R6: Transmit bytes are sent starting with bits [7:0] of data word 0 and go on upward through each word and then to the next word.
- R7: Received bits are sampled on the SCLK rising edge. They are packed in arrival order into bytes from bits [7:0] of data word 0 upward. Within a byte, the first bit goes to bit 7, or to bit 0 when LSB-first is set.
- R8: Mode bit 3 selects LSB-first order within each byte for all three phases. Mode bits 4 and 5 always read 0 and do not change the SCLK timing.
- R9: MOSI is low during receive bits and whenever the block is idle.
- R10: Setting bit n of the chip-select register drives `cs_n[n]` low, and clearing it drives `cs_n[n]` high. The pins change only through register writes.
- R11: While busy, every register write is ignored, including a repeated start. The running transaction keeps its counts and length.
- R12: Busy stays high for exactly N*P cycles, where N is the total bit count. It clears in the same cycle that the final received bit is written into the buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | Write enable, qualified by reg_en |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the strobe cycle |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | CS_COUNT | Active-low chip selects |

## Verification
The bench builds the block with its defaults: eight data words, two chip selects and a 12-bit divider field. With these defaults a 256-bit receive fills every data word, and a command count of 63 reaches the clamp. Divider values 0, 1, 2 and 3 give both even and odd bit periods, so the unequal high and low halves are exercised. The fastest period also keeps full-buffer transfers short.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    typedef enum logic [1:0] {
        PH_CMD = 2'd0,
        PH_TX  = 2'd1,
        PH_RX  = 2'd2
    } phase_e;

    localparam logic [7:0] OFS_XFER  = 8'h00;
    localparam logic [7:0] OFS_CMD   = 8'h04;
    localparam logic [7:0] OFS_DATA0 = 8'h08;
    localparam logic [7:0] OFS_MODE  = 8'h28;
    localparam logic [7:0] OFS_COUNT = 8'h2C;
    localparam logic [7:0] OFS_CSEL  = 8'h38;

    localparam int START_BIT = 8;
    localparam int BUSY_BIT  = 16;
    localparam int LSB_BIT   = 3;
    localparam int DIV_LSB   = 16;
    localparam int CMD_CAP   = 32;

endpackage

// File: rtl/spi_seq_clkgen.sv
module spi_seq_clkgen #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             sclk,
    output logic             rise,
    output logic             bit_end
);
    localparam int CNT_W = DIV_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sclk;
    } cg_t;

    cg_t cg_d, cg_q;
    logic [CNT_W-1:0] period, low_len;

    assign period  = {1'b0, div} + CNT_W'(2);
    assign low_len = period - (period >> 1);
    assign rise    = run && (cg_q.cnt == low_len - CNT_W'(1));
    assign bit_end = run && (cg_q.cnt == period - CNT_W'(1));
    assign sclk    = cg_q.sclk;

    always_comb begin
        cg_d = cg_q;
        if (!run || bit_end) begin
            cg_d.cnt = '0;
        end else begin
            cg_d.cnt = cg_q.cnt + CNT_W'(1);
        end
        cg_d.sclk = run && !bit_end && ((cg_q.cnt + CNT_W'(1)) >= low_len);
    end

    always_ff @(posedge clk) begin
        if (rst) cg_q <= '0;
        else     cg_q <= cg_d;
    end
endmodule

// File: rtl/spi_seq_bitmap.sv
module spi_seq_bitmap
    import spi_seq_pkg::*;
#(
    parameter int BIT_W  = 10,
    parameter int DIDX_W = 8
) (
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic [BIT_W-1:0]  cmd_n,
    input  logic [BIT_W-1:0]  tx_n,
    input  logic              lsb_first,
    output phase_e            phase,
    output logic [4:0]        cmd_sel,
    output logic [DIDX_W-1:0] dat_sel
);
    logic [BIT_W-1:0] off, tx_end;
    logic [2:0]       in_byte;

    assign tx_end = cmd_n + tx_n;

    always_comb begin
        if (bit_idx < cmd_n) begin
            phase = PH_CMD;
            off   = bit_idx;
        end else if (bit_idx < tx_end) begin
            phase = PH_TX;
            off   = bit_idx - cmd_n;
        end else begin
            phase = PH_RX;
            off   = bit_idx - tx_end;
        end
    end

    assign in_byte = lsb_first ? off[2:0] : ~off[2:0];
    // command bytes run from the top byte down
    assign cmd_sel = {~off[4:3], in_byte};
    assign dat_sel = {off[DIDX_W-1:3], in_byte};
endmodule

// File: rtl/spi_seq_master.sv
module spi_seq_master
    import spi_seq_pkg::*;
#(
    parameter int DATA_WORDS = 8,
    parameter int CS_COUNT   = 2,
    parameter int DIV_W      = 12,
    parameter int ADDR_W     = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_en,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic                sclk,
    output logic                mosi,
    input  logic                miso,
    output logic [CS_COUNT-1:0] cs_n
);
    localparam int DAT_BITS = 32 * DATA_WORDS;
    localparam int DIDX_W   = $clog2(DAT_BITS);
    localparam int RAW_BW   = $clog2(CMD_CAP + 2 * DAT_BITS + 1);
    localparam int BIT_W    = (RAW_BW > 10) ? RAW_BW : 10;

    typedef struct packed {
        logic                busy;
        logic [BIT_W-1:0]    bit_idx;
        logic                rx_bit;
        logic [5:0]          cmd_cfg;
        logic [8:0]          tx_cfg;
        logic [8:0]          rx_cfg;
        logic [31:0]         cmd_word;
        logic [DAT_BITS-1:0] dat;
        logic                lsb;
        logic [DIV_W-1:0]    div;
        logic [CS_COUNT-1:0] csel;
    } st_t;

    st_t st_d, st_q;

    logic [BIT_W-1:0]  cmd_eff, tx_eff, rx_eff, total_bits;
    logic              rise, bit_end;
    phase_e            ph;
    logic [4:0]        cmd_sel;
    logic [DIDX_W-1:0] dat_sel;
    logic              wr_ok;
    logic [31:0]       word_rd [DATA_WORDS];

    assign cmd_eff = (st_q.cmd_cfg > 6'(CMD_CAP)) ? BIT_W'(CMD_CAP) : BIT_W'(st_q.cmd_cfg);
    assign tx_eff  = (BIT_W'(st_q.tx_cfg) > BIT_W'(DAT_BITS)) ? BIT_W'(DAT_BITS) : BIT_W'(st_q.tx_cfg);
    assign rx_eff  = (BIT_W'(st_q.rx_cfg) > BIT_W'(DAT_BITS)) ? BIT_W'(DAT_BITS) : BIT_W'(st_q.rx_cfg);
    assign total_bits = cmd_eff + tx_eff + rx_eff;
    assign wr_ok = reg_en && reg_we && !st_q.busy;

    spi_seq_clkgen #(.DIV_W(DIV_W)) i_clkgen (
        .clk     (clk),
        .rst     (rst),
        .run     (st_q.busy),
        .div     (st_q.div),
        .sclk    (sclk),
        .rise    (rise),
        .bit_end (bit_end)
    );

    spi_seq_bitmap #(.BIT_W(BIT_W), .DIDX_W(DIDX_W)) i_bitmap (
        .bit_idx   (st_q.bit_idx),
        .cmd_n     (cmd_eff),
        .tx_n      (tx_eff),
        .lsb_first (st_q.lsb),
        .phase     (ph),
        .cmd_sel   (cmd_sel),
        .dat_sel   (dat_sel)
    );

    always_comb begin
        st_d = st_q;
        if (wr_ok) begin
            case (reg_addr)
                ADDR_W'(OFS_XFER): begin
                    if (reg_wdata[START_BIT] && (total_bits != '0)) begin
                        st_d.busy    = 1'b1;
                        st_d.bit_idx = '0;
                    end
                end
                ADDR_W'(OFS_CMD):  st_d.cmd_word = reg_wdata;
                ADDR_W'(OFS_MODE): begin
                    st_d.lsb = reg_wdata[LSB_BIT];
                    st_d.div = reg_wdata[DIV_LSB +: DIV_W];
                end
                ADDR_W'(OFS_COUNT): begin
                    st_d.cmd_cfg = reg_wdata[29:24];
                    st_d.rx_cfg  = reg_wdata[20:12];
                    st_d.tx_cfg  = reg_wdata[8:0];
                end
                ADDR_W'(OFS_CSEL): st_d.csel = reg_wdata[CS_COUNT-1:0];
                default: begin
                    for (int w = 0; w < DATA_WORDS; w++) begin
                        if (reg_addr == ADDR_W'(OFS_DATA0 + 4 * w)) begin
                            st_d.dat[32*w +: 32] = reg_wdata;
                        end
                    end
                end
            endcase
        end
        if (st_q.busy) begin
            if (rise) st_d.rx_bit = miso;
            if (bit_end) begin
                // receive bit lands at the close of its bit period
                if (ph == PH_RX) st_d.dat[dat_sel] = st_q.rx_bit;
                if (st_q.bit_idx == total_bits - BIT_W'(1)) begin
                    st_d.busy = 1'b0;
                end else begin
                    st_d.bit_idx = st_q.bit_idx + BIT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign mosi = st_q.busy &&
                  (((ph == PH_CMD) && st_q.cmd_word[cmd_sel]) ||
                   ((ph == PH_TX)  && st_q.dat[dat_sel]));

    generate
        for (genvar w = 0; w < DATA_WORDS; w++) begin : g_word
            assign word_rd[w] = st_q.dat[32*w +: 32];
        end
        for (genvar c = 0; c < CS_COUNT; c++) begin : g_cs
            assign cs_n[c] = ~st_q.csel[c];
        end
    endgenerate

    always_comb begin
        reg_rdata = '0;
        if (reg_en && !reg_we) begin
            case (reg_addr)
                ADDR_W'(OFS_XFER): reg_rdata[BUSY_BIT] = st_q.busy;
                ADDR_W'(OFS_CMD):  reg_rdata = st_q.cmd_word;
                ADDR_W'(OFS_MODE): begin
                    reg_rdata[LSB_BIT]            = st_q.lsb;
                    reg_rdata[DIV_LSB +: DIV_W]   = st_q.div;
                end
                ADDR_W'(OFS_COUNT): begin
                    reg_rdata[29:24] = st_q.cmd_cfg;
                    reg_rdata[20:12] = st_q.rx_cfg;
                    reg_rdata[8:0]   = st_q.tx_cfg;
                end
                ADDR_W'(OFS_CSEL): reg_rdata[CS_COUNT-1:0] = st_q.csel;
                default: begin
                    for (int w = 0; w < DATA_WORDS; w++) begin
                        if (reg_addr == ADDR_W'(OFS_DATA0 + 4 * w)) reg_rdata = word_rd[w];
                    end
                end
            endcase
        end
    end

    logic [15:0] chk_bit_idx, chk_total;
    assign chk_bit_idx = 16'(st_q.bit_idx);
    assign chk_total   = 16'(total_bits);
endmodule

// File: rtl/spi_seq_checks.sv
module spi_seq_checks #(
    parameter int CS_COUNT = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                busy,
    input logic                sclk,
    input logic                mosi,
    input logic                reg_en,
    input logic                reg_we,
    input logic [CS_COUNT-1:0] cs_n,
    input logic [15:0]         bit_idx,
    input logic [15:0]         total_bits
);
    assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sclk);

    assert_mosi_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mosi);

    assert_rise_in_xfer_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> busy);

    assert_idx_range_R12: assert property (@(posedge clk) disable iff (rst)
        busy |-> (bit_idx < total_bits));

    assert_count_hold_R11: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || $stable(total_bits)));

    assert_idx_forward_R11: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || (bit_idx >= $past(bit_idx))));

    assert_cs_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !(reg_en && reg_we) |=> $stable(cs_n));
endmodule

bind spi_seq_master spi_seq_checks #(.CS_COUNT(CS_COUNT)) i_checks (
    .clk        (clk),
    .rst        (rst),
    .busy       (st_q.busy),
    .sclk       (sclk),
    .mosi       (mosi),
    .reg_en     (reg_en),
    .reg_we     (reg_we),
    .cs_n       (cs_n),
    .bit_idx    (chk_bit_idx),
    .total_bits (chk_total)
);

// File: tb/test_spi_seq_master.sv
module test_spi_seq_master;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_XFER = 8'h00, A_CMD = 8'h04, A_DATA0 = 8'h08,
                           A_MODE = 8'h28, A_CNT = 8'h2C, A_CSEL = 8'h38;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_en = 1'b0, reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        sclk, mosi, miso = 1'b0;
    logic [1:0]  cs_n;

    int checks = 0, errors = 0;

    // expectation model
    logic [31:0]  b_cmd = '0;
    logic [255:0] b_dat = '0;
    logic [255:0] pat   = '0;
    logic         b_lsb = 1'b0;
    int           b_p   = 2;
    int           cmd_n = 0, tx_n = 0, rx_n = 0, rx_pre = 0;

    // serial monitor
    logic log_bits [0:1023];
    int   n_rise = 0;
    time  t_rise = 0, last_period = 0, last_high = 0;

    spi_seq_master i_spi_seq_master (
        .clk(clk), .rst(rst), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge sclk) begin
        if (n_rise > 0) last_period = $time - t_rise;
        t_rise = $time;
        if (n_rise < 1024) log_bits[n_rise] = mosi;
        n_rise = n_rise + 1;
    end

    always @(negedge sclk) begin
        last_high = $time - t_rise;
        if (n_rise >= rx_pre && n_rise - rx_pre < 256) miso = pat[n_rise - rx_pre];
        else miso = 1'b0;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        reg_en = 1'b0;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = A_XFER;
        #1;
        while (reg_rdata[16] && cyc < 20000) begin
            cyc++;
            @(negedge clk);
            #1;
        end
        reg_en = 1'b0;
    endtask

    task automatic set_data(input int w, input logic [31:0] v);
        reg_write(A_DATA0 + 8'(4 * w), v);
        b_dat[32*w +: 32] = v;
    endtask

    task automatic set_mode(input logic lsb, input int div, input logic [31:0] extra);
        reg_write(A_MODE, extra | (32'(lsb) << 3) | (32'(div) << 16));
        b_lsb = lsb;
        b_p   = div + 2;
    endtask

    function automatic int in_byte(input int k);
        return b_lsb ? (k % 8) : (7 - k % 8);
    endfunction

    function automatic logic exp_mosi(input int k);
        if (k < cmd_n) return b_cmd[(3 - k / 8) * 8 + in_byte(k)];
        if (k < cmd_n + tx_n) return b_dat[8 * ((k - cmd_n) / 8) + in_byte(k - cmd_n)];
        return 1'b0;
    endfunction

    // runs one transaction and checks stream, length, timing and buffer
    task automatic do_xfer(input int cf, input int tf, input int rf);
        int cyc, n, e_cmd, e_tx, e_rx;
        logic [31:0] d;
        cmd_n = (cf > 32) ? 32 : cf;
        tx_n  = (tf > 256) ? 256 : tf;
        rx_n  = (rf > 256) ? 256 : rf;
        rx_pre = cmd_n + tx_n;
        n = cmd_n + tx_n + rx_n;
        reg_write(A_CNT, (32'(cf) << 24) | (32'(rf) << 12) | 32'(tf));
        miso = (rx_pre == 0) ? pat[0] : 1'b0;
        n_rise = 0;
        reg_write(A_XFER, 32'h0000_0100);
        wait_idle(cyc);
        chk("R12 busy cycles", 32'(cyc), 32'(n * b_p));
        chk("R4 sclk pulses", 32'(n_rise), 32'(n));
        e_cmd = 0; e_tx = 0; e_rx = 0;
        for (int k = 0; k < n; k++) begin
            if (log_bits[k] !== exp_mosi(k)) begin
                if (k < cmd_n) e_cmd++;
                else if (k < rx_pre) e_tx++;
                else e_rx++;
            end
        end
        chk("R5 command stream errors", 32'(e_cmd), 32'd0);
        chk("R6 transmit stream errors", 32'(e_tx), 32'd0);
        chk("R9 mosi low in receive", 32'(e_rx), 32'd0);
        for (int r = 0; r < rx_n; r++) b_dat[8 * (r / 8) + in_byte(r)] = pat[r];
        for (int w = 0; w < 8; w++) begin
            reg_read(A_DATA0 + 8'(4 * w), d);
            chk("R7 data word after transfer", d, b_dat[32*w +: 32]);
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        reg_read(A_XFER, d); chk("R1 status after reset", d, 32'h0);
        reg_read(A_MODE, d); chk("R1 mode after reset", d, 32'h0);
        chk("R10 cs_n after reset", 32'(cs_n), 32'h3);
        chk("R3 sclk idle", 32'(sclk), 32'h0);
        chk("R9 mosi idle", 32'(mosi), 32'h0);
    endtask

    task automatic t_regs;
        logic [31:0] d;
        reg_write(A_CMD, 32'h1234_5678); b_cmd = 32'h1234_5678;
        reg_read(A_CMD, d); chk("R1 command readback", d, 32'h1234_5678);
        set_data(5, 32'hCAFE_0001);
        reg_read(A_DATA0 + 8'd20, d); chk("R1 data word readback", d, 32'hCAFE_0001);
        reg_write(A_CNT, 32'h2010_3055);
        reg_read(A_CNT, d); chk("R1 count readback", d, 32'h2010_3055 & 32'h3F1F_F1FF);
    endtask

    task automatic t_cmd_only;
        set_mode(1'b0, 0, 32'h0);
        reg_write(A_CMD, 32'h9F00_0000); b_cmd = 32'h9F00_0000;
        do_xfer(8, 0, 0);
        chk("R3 period div0", 32'(last_period), 32'(2 * CLK_PERIOD));
        chk("R3 high time div0", 32'(last_high), 32'(CLK_PERIOD));
    endtask

    task automatic t_mixed;
        set_mode(1'b0, 1, 32'h0);
        reg_write(A_CMD, 32'hA1B2_C3D4); b_cmd = 32'hA1B2_C3D4;
        set_data(0, 32'h4433_2211);
        set_data(1, 32'h0000_00F5);
        pat = {8{32'h5A3C_96E1}};
        do_xfer(32, 40, 24);
        chk("R3 period odd divisor", 32'(last_period), 32'(3 * CLK_PERIOD));
        chk("R3 high time odd divisor", 32'(last_high), 32'(CLK_PERIOD));
    endtask

    task automatic t_lsb;
        logic [31:0] d;
        set_mode(1'b1, 2, 32'h0000_0030);
        reg_read(A_MODE, d); chk("R8 mode bits 4 and 5 read zero", d, 32'h0002_0008);
        reg_write(A_CMD, 32'h0300_0000); b_cmd = 32'h0300_0000;
        set_data(0, 32'h0000_80C1);
        pat = {8{32'hE4D1_0B27}};
        do_xfer(8, 16, 16);
        chk("R8 period unchanged by bits 4 and 5", 32'(last_period), 32'(4 * CLK_PERIOD));
        chk("R8 high time", 32'(last_high), 32'(2 * CLK_PERIOD));
    endtask

    task automatic t_rx_full;
        set_mode(1'b0, 0, 32'h0);
        for (int i = 0; i < 256; i++) pat[i] = ((i * 37 + 11) % 7) < 3;
        do_xfer(0, 0, 256);
    endtask

    task automatic t_busy_ignore;
        int cyc;
        logic [31:0] d;
        set_mode(1'b0, 3, 32'h0);
        set_data(7, 32'h0BAD_F00D);
        reg_write(A_CNT, 32'h0000_0040);
        n_rise = 0;
        rx_pre = 64;
        reg_write(A_XFER, 32'h0000_0100);
        reg_write(A_DATA0 + 8'd28, 32'hDEAD_BEEF);
        reg_write(A_CNT, 32'h2000_0010);
        reg_write(A_CSEL, 32'h3);
        reg_write(A_XFER, 32'h0000_0100);
        wait_idle(cyc);
        chk("R11 pulses after restart attempt", 32'(n_rise), 32'd64);
        reg_read(A_DATA0 + 8'd28, d); chk("R11 data word kept", d, 32'h0BAD_F00D);
        reg_read(A_CNT, d); chk("R11 counts kept", d, 32'h0000_0040);
        chk("R11 cs_n kept", 32'(cs_n), 32'h3);
    endtask

    task automatic t_zero;
        logic [31:0] d;
        reg_write(A_CNT, 32'h0);
        n_rise = 0;
        reg_write(A_XFER, 32'h0000_0100);
        reg_read(A_XFER, d); chk("R2 zero count stays idle", d, 32'h0);
        repeat (10) @(negedge clk);
        chk("R2 zero count no sclk", 32'(n_rise), 32'd0);
    endtask

    task automatic t_clamp;
        set_mode(1'b0, 0, 32'h0);
        reg_write(A_CMD, 32'h8421_F00F); b_cmd = 32'h8421_F00F;
        do_xfer(63, 0, 0);
    endtask

    task automatic t_cs;
        logic [31:0] d;
        reg_write(A_CSEL, 32'h1); chk("R10 select device 0", 32'(cs_n), 32'h2);
        reg_write(A_CSEL, 32'h2); chk("R10 select device 1", 32'(cs_n), 32'h1);
        reg_read(A_CSEL, d);      chk("R10 readback", d, 32'h2);
        reg_write(A_CSEL, 32'h0); chk("R10 release", 32'(cs_n), 32'h3);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_cs();
        t_cmd_only();
        t_mixed();
        t_lsb();
        t_rx_full();
        t_busy_ignore();
        t_zero();
        t_clamp();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule